// File: doc/BRIEF.md
# SPI Burst Memory Access Slave

This block lets an external SPI host move data in bursts to and from an on-chip memory that is 64 bits wide. The host frames each transaction with chip select. The first byte is an operation code and the next four bytes are a byte address. A burst read then takes four filler bytes, after which the slave streams memory contents. A burst write carries data bytes, and the host ends it with one extra copy of the operation code.

Data always travels in 8-byte units. A unit maps onto one memory word. On the wire the bytes of a unit appear from the highest byte address down to the lowest. The SPI pins are sampled into the system clock domain through a two-flop synchroniser, so SCLK has to be several times slower than the system clock. The slave drives a plain synchronous memory port: the read data arrives one clock after the address.

Top module: `spi_burst_slave`

## Requirements
- R1: After reset, and whenever CS_n is high, `miso` is low and `mem_we` is low.
- R2: Operation code 4 selects a burst read and code 5 selects a burst write. The four address bytes that follow are sent most significant byte first and form a byte address. Bits [2:0] of that address are ignored, and the starting word is address bits [MEM_AW+2:3].
- R3: In a burst read, the four bytes after the address are filler. Read data starts with frame byte 9, counting the operation code as byte 0. A read never asserts `mem_we`.
- R4: A memory byte at address 8w+L is lane L of word w, which is bits [8L+7:8L]. Unit byte j on the wire, for j from 0 to 7, is lane 7-j of its word. This holds in both directions.
- R5: In a read, consecutive 8-byte units come from consecutive word addresses. The next word is fetched while the current unit is being shifted out, so a stream runs with no gaps.
- R6: In a write, each complete group of 8 data bytes produces a single-cycle `mem_we` pulse. The pulses go to consecutive word addresses, starting at the addressed word.
- R7: The trailing copy of the operation code, and any data group of fewer than 8 bytes, are never written.
- R8: Operation codes 0 to 3 and any code above 5 are ignored for the rest of the frame. No write occurs and `miso` stays low.
- R9: Raising CS_n at any point aborts the frame and drops any partial write group. The next frame is parsed from its operation byte.
- R10: A transaction of 240 data bytes, followed by a second transaction whose address is 240 higher, reads or writes one contiguous memory range.
- R11: SPI mode 0 is used. MOSI is sampled on the rising SCLK edge, MISO changes on the falling edge, and bits go most significant first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_we | output | 1 | Memory write enable, one cycle per word |
| mem_rdata | input | 64 | Memory read data, valid one cycle after the address |

## Verification
Each data byte carries a distinct value. A write then read-back shows whether the byte order inside each unit is reversed, and whether the word addresses step by one. The 240-byte stream, followed by a second frame 240 bytes higher, shows whether prefetching keeps up over many units and whether the two frames meet without a gap or an overlap. A read at an unaligned address tells an ignored low address field apart from one that is honoured. The ignored-code frames, the frames aborted mid-unit, and the trailing command byte all leave a word untouched. Reading that word back afterwards shows whether anything leaked into memory.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int UNIT_BYTES = 8;
  localparam int UNIT_W     = 8 * UNIT_BYTES;
  localparam int ADDR_BYTES = 4;
  localparam int FILL_BYTES = 4;

  localparam logic [7:0] OP_BURST_RD = 8'd4;
  localparam logic [7:0] OP_BURST_WR = 8'd5;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_FILL,
    PH_RDATA,
    PH_WDATA,
    PH_SKIP
  } phase_e;

  // Phase entered after the operation byte.
  function automatic phase_e phase_after_op(logic [7:0] op);
    return (op == OP_BURST_RD || op == OP_BURST_WR) ? PH_ADDR : PH_SKIP;
  endfunction

  // Byte address to word address: the lane bits are dropped.
  function automatic logic [31:0] byte_to_word(logic [31:0] a);
    return a >> 3;
  endfunction

  // The first wire byte of a unit ends up in the top lane.
  function automatic logic [UNIT_W-1:0] unit_push(logic [UNIT_W-9:0] prev, logic [7:0] b);
    return {prev, b};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic frame_on,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);

  logic [STAGES-1:0] sclk_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] mosi_pipe;
  logic              sclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '0;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
      cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
      sclk_last <= sclk_pipe[STAGES-1];
    end
  end

  assign frame_on  = ~cs_pipe[STAGES-1];
  assign mosi_s    = mosi_pipe[STAGES-1];
  assign sclk_rise = frame_on &  sclk_pipe[STAGES-1] & ~sclk_last;
  assign sclk_fall = frame_on & ~sclk_pipe[STAGES-1] &  sclk_last;

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int UNIT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [UNIT_W-1:0] tx_word,
  output logic              byte_done,
  output logic [7:0]        rx_byte,
  output logic              at_boundary,
  output logic              miso
);

  logic [2:0]        bitcnt;
  logic [6:0]        rx_sh;
  logic [UNIT_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
    end else if (!frame_on) begin
      bitcnt <= '0;
      tx_sh  <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sh  <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (sclk_fall) begin
        // A whole unit goes out MSB first, which reverses its bytes.
        if (tx_load) tx_sh <= tx_word;
        else         tx_sh <= {tx_sh[UNIT_W-2:0], 1'b0};
      end
    end
  end

  assign rx_byte     = {rx_sh, mosi_s};
  assign byte_done   = sclk_rise && (bitcnt == 3'd7);
  assign at_boundary = (bitcnt == 3'd0);
  assign miso        = tx_sh[UNIT_W-1];

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              sclk_fall,
  input  logic              at_boundary,
  input  logic [UNIT_W-1:0] mem_rdata,
  output logic              tx_load,
  output logic [UNIT_W-1:0] tx_word,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [UNIT_W-1:0] mem_wdata,
  output logic              mem_we
);

  localparam int KEEP_W = MEM_AW + 3;

  phase_e             phase;
  logic [2:0]         sub;
  logic               is_rd;
  logic [KEEP_W-1:0]  addr_acc;
  logic [KEEP_W-1:0]  full_keep;
  logic [MEM_AW-1:0]  start_word;
  logic [MEM_AW-1:0]  rd_ptr;
  logic [MEM_AW-1:0]  wr_ptr;
  logic [1:0]         fetch_q;
  logic [UNIT_W-1:0]  pf_buf;
  logic               pf_valid;
  logic [UNIT_W-9:0]  wbuf;
  logic               addr_last;
  logic               fetch_go;
  logic               unit_commit;

  assign full_keep   = KEEP_W'({addr_acc, rx_byte});
  assign start_word  = MEM_AW'(byte_to_word(32'(full_keep)));
  assign addr_last   = byte_done && (phase == PH_ADDR) && (sub == 3'(ADDR_BYTES - 1));
  assign tx_load     = sclk_fall && at_boundary && (phase == PH_RDATA) && (sub == 3'd0);
  assign fetch_go    = (addr_last && is_rd) || tx_load;
  assign unit_commit = byte_done && (phase == PH_WDATA) && (sub == 3'(UNIT_BYTES - 1));
  assign tx_word     = pf_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      sub       <= '0;
      is_rd     <= 1'b0;
      addr_acc  <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      fetch_q   <= '0;
      pf_buf    <= '0;
      pf_valid  <= 1'b0;
      wbuf      <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else if (!frame_on) begin
      phase    <= PH_CMD;
      sub      <= '0;
      fetch_q  <= '0;
      pf_valid <= 1'b0;
      mem_we   <= 1'b0;
    end else begin
      mem_we  <= unit_commit;
      fetch_q <= {fetch_q[0], fetch_go};
      if (fetch_q[1]) begin
        pf_buf   <= mem_rdata;
        pf_valid <= 1'b1;
      end
      if (tx_load) begin
        pf_valid <= 1'b0;
        mem_addr <= rd_ptr;
        rd_ptr   <= rd_ptr + MEM_AW'(1);
      end
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            is_rd <= (rx_byte == OP_BURST_RD);
            phase <= phase_after_op(rx_byte);
            sub   <= '0;
          end
          PH_ADDR: begin
            addr_acc <= full_keep;
            sub      <= sub + 3'd1;
            if (addr_last) begin
              sub <= '0;
              if (is_rd) begin
                phase    <= PH_FILL;
                mem_addr <= start_word;
                rd_ptr   <= start_word + MEM_AW'(1);
              end else begin
                phase  <= PH_WDATA;
                wr_ptr <= start_word;
              end
            end
          end
          PH_FILL: begin
            sub <= sub + 3'd1;
            if (sub == 3'(FILL_BYTES - 1)) begin
              sub   <= '0;
              phase <= PH_RDATA;
            end
          end
          PH_RDATA: sub <= sub + 3'd1;
          PH_WDATA: begin
            wbuf <= (UNIT_W-8)'(unit_push(wbuf, rx_byte));
            sub  <= sub + 3'd1;
            if (unit_commit) begin
              mem_addr  <= wr_ptr;
              mem_wdata <= unit_push(wbuf, rx_byte);
              wr_ptr    <= wr_ptr + MEM_AW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_read_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FILL || phase == PH_RDATA) |-> !mem_we);

  assert_skip_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!mem_we && !tx_load));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> (phase == PH_CMD && sub == 3'd0 && !pf_valid && !mem_we));

  assert_prefetch_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> pf_valid);

endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import spi_burst_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              mem_we,
  input  logic [63:0]       mem_rdata
);

  logic              frame_on;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              mosi_s;
  logic              byte_done;
  logic [7:0]        rx_byte;
  logic              at_boundary;
  logic              tx_load;
  logic [UNIT_W-1:0] tx_word;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .frame_on  (frame_on),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s)
  );

  spi_bit_engine #(.UNIT_W(UNIT_W)) u_bits (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_on    (frame_on),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .mosi_s      (mosi_s),
    .tx_load     (tx_load),
    .tx_word     (tx_word),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .at_boundary (at_boundary),
    .miso        (miso)
  );

  spi_burst_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_on    (frame_on),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .sclk_fall   (sclk_fall),
    .at_boundary (at_boundary),
    .mem_rdata   (mem_rdata),
    .tx_load     (tx_load),
    .tx_word     (tx_word),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> (!miso && !mem_we));

endmodule

// File: tb/sim_spi_burst_slave.sv
`timescale 1ns/1ps
module sim_spi_burst_slave;

  localparam int AW = 8;
  localparam int H  = 6;   // clk cycles per SCLK half period

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          cs_n = 1'b1;
  logic          mosi = 1'b0;
  logic          miso;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          mem_we;
  logic [63:0]   mem_rdata = '0;

  logic [63:0] mem [0:(1<<AW)-1];
  logic [7:0]  txq [0:299];
  logic [7:0]  rxq [0:299];
  int errors = 0;
  int checks = 0;
  int we_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_burst_slave #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory byte at byte address a: word a/8, lane a%8.
  function automatic logic [7:0] mem_byte(input int a);
    return mem[(a / 8) % (1 << AW)][8 * (a % 8) +: 8];
  endfunction

  // Wire position s of a stream starting at byte address base.
  function automatic int wire_to_addr(input int base, input int s);
    return base + 8 * (s / 8) + (7 - (s % 8));
  endfunction

  task automatic set_hdr(input logic [7:0] op, input logic [31:0] a);
    txq[0] = op;
    txq[1] = a[31:24];
    txq[2] = a[23:16];
    txq[3] = a[15:8];
    txq[4] = a[7:0];
  endtask

  task automatic run_frame(input int n);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        sclk = 1'b0;
        mosi = txq[i][b];
        repeat (H) @(negedge clk);
        r[b] = miso;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
      end
      rxq[i] = r;
    end
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(miso == 1'b0, "R1 miso idle", 64'(miso), 64'd0);
    chk(mem_we == 1'b0, "R1 we idle", 64'(mem_we), 64'd0);
  endtask

  task automatic t_write_basic;
    int base;
    logic [63:0] keep;
    base = we_cnt;
    keep = mem[18];
    set_hdr(8'd5, 32'h80);
    for (int k = 0; k < 16; k++) txq[5 + k] = 8'h10 + 8'(k);
    txq[21] = 8'd5;
    run_frame(22);
    chk(we_cnt - base == 2, "R6 pulse count", 64'(we_cnt - base), 64'd2);
    for (int s = 0; s < 16; s++)
      chk(mem_byte(wire_to_addr(32'h80, s)) == txq[5 + s], "R4/R6 write lane",
          64'(mem_byte(wire_to_addr(32'h80, s))), 64'(txq[5 + s]));
    chk(mem[18] == keep, "R7 trailing op not written", mem[18], keep);
    chk(miso == 1'b0, "R1 miso after frame", 64'(miso), 64'd0);
  endtask

  task automatic t_read_basic;
    set_hdr(8'd4, 32'h80);
    run_frame(5 + 4 + 16);
    for (int s = 0; s < 16; s++)
      chk(rxq[9 + s] == mem_byte(wire_to_addr(32'h80, s)), "R3/R4/R11 read byte",
          64'(rxq[9 + s]), 64'(mem_byte(wire_to_addr(32'h80, s))));
    set_hdr(8'd4, 32'h87);
    run_frame(5 + 4 + 8);
    for (int s = 0; s < 8; s++)
      chk(rxq[9 + s] == mem_byte(wire_to_addr(32'h80, s)), "R2 low bits ignored",
          64'(rxq[9 + s]), 64'(mem_byte(wire_to_addr(32'h80, s))));
  endtask

  function automatic logic [7:0] long_pat(input int s);
    return 8'((s * 7 + 3) ^ (s >> 3));
  endfunction

  task automatic t_long_split;
    int base;
    base = we_cnt;
    set_hdr(8'd5, 32'h100);
    for (int s = 0; s < 240; s++) txq[5 + s] = long_pat(s);
    txq[245] = 8'd5;
    run_frame(246);
    set_hdr(8'd5, 32'h100 + 240);
    for (int s = 0; s < 16; s++) txq[5 + s] = long_pat(240 + s);
    txq[21] = 8'd5;
    run_frame(22);
    chk(we_cnt - base == 32, "R6/R10 word count", 64'(we_cnt - base), 64'd32);
    for (int s = 0; s < 256; s++)
      chk(mem_byte(wire_to_addr(32'h100, s)) == long_pat(s), "R10 write range",
          64'(mem_byte(wire_to_addr(32'h100, s))), 64'(long_pat(s)));
    set_hdr(8'd4, 32'h100);
    run_frame(5 + 4 + 240);
    for (int s = 0; s < 240; s++)
      chk(rxq[9 + s] == long_pat(s), "R5/R10 long read", 64'(rxq[9 + s]), 64'(long_pat(s)));
    set_hdr(8'd4, 32'h100 + 240);
    run_frame(5 + 4 + 16);
    for (int s = 0; s < 16; s++)
      chk(rxq[9 + s] == long_pat(240 + s), "R10 second read", 64'(rxq[9 + s]), 64'(long_pat(240 + s)));
  endtask

  task automatic t_ignored;
    logic [7:0] ops [5];
    logic [63:0] keep;
    logic [7:0] acc;
    int base;
    ops = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7};
    foreach (ops[i]) begin
      base = we_cnt;
      keep = mem[64];
      set_hdr(ops[i], 32'h200);
      for (int k = 0; k < 8; k++) txq[5 + k] = 8'hEE;
      run_frame(13);
      acc = '0;
      for (int k = 0; k < 13; k++) acc = acc | rxq[k];
      chk(we_cnt == base, "R8 no write", 64'(we_cnt - base), 64'd0);
      chk(mem[64] == keep, "R8 word untouched", mem[64], keep);
      chk(acc == 8'd0, "R8 miso low", 64'(acc), 64'd0);
    end
  endtask

  task automatic t_abort;
    logic [63:0] keep;
    int base;
    base = we_cnt;
    keep = mem[80];
    set_hdr(8'd5, 32'h280);
    for (int k = 0; k < 5; k++) txq[5 + k] = 8'h5A;
    run_frame(10);
    chk(we_cnt == base, "R9 partial dropped", 64'(we_cnt - base), 64'd0);
    chk(mem[80] == keep, "R9 word kept", mem[80], keep);
    set_hdr(8'd4, 32'h280);
    run_frame(11);
    for (int s = 0; s < 2; s++)
      chk(rxq[9 + s] == mem_byte(wire_to_addr(32'h280, s)), "R9 cut read",
          64'(rxq[9 + s]), 64'(mem_byte(wire_to_addr(32'h280, s))));
    set_hdr(8'd4, 32'h280);
    run_frame(17);
    for (int s = 0; s < 8; s++)
      chk(rxq[9 + s] == mem_byte(wire_to_addr(32'h280, s)), "R9 read after abort",
          64'(rxq[9 + s]), 64'(mem_byte(wire_to_addr(32'h280, s))));
    set_hdr(8'd5, 32'h280);
    for (int k = 0; k < 8; k++) txq[5 + k] = 8'hC0 + 8'(k);
    txq[13] = 8'd5;
    run_frame(14);
    for (int s = 0; s < 8; s++)
      chk(mem_byte(wire_to_addr(32'h280, s)) == 8'hC0 + 8'(s), "R9 write after abort",
          64'(mem_byte(wire_to_addr(32'h280, s))), 64'(8'hC0 + 8'(s)));
  endtask

  initial begin
    for (int w = 0; w < (1 << AW); w++)
      for (int l = 0; l < 8; l++) mem[w][8 * l +: 8] = 8'(w * 8 + l) ^ 8'h3C;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_basic();
    t_read_basic();
    t_long_split();
    t_ignored();
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule